// File: doc/BRIEF.md
# PCIe TLP Bandwidth Filter Counter

This block watches a stream of transaction-layer packet descriptors and adds up the length, in doublewords, of every packet that passes a set of filters. Each descriptor arrives as a one-cycle strobe with a root-port index, the 16-bit requester identifier (bus/device/function) and a length. Static configuration inputs choose the event class, which root ports are watched, and whether a requester match, a one-shot length trigger and a per-packet length window apply.

The trigger is sticky. Counting starts with the first packet whose length meets the trigger comparison, and it continues from then on even when later packets miss that comparison. The threshold window, by contrast, is evaluated separately for every packet. The requester, trigger and threshold filters act only in the bandwidth event class. Settings that ask for two conflicting selections are flagged as invalid, and nothing is counted while such a setting is present.

The counter saturates at all ones. A synchronous clear empties it and drops the trigger arming. The configuration is expected to stay still while counting is enabled.

Top module: `pcie_bw_filter_counter`

## Requirements
- R1: After reset, or in the cycle after `cnt_clr` is high, `count` is 0 and `armed` is 0. The clear takes priority over a packet in the same cycle.
- R2: With `cfg_port_en` high, a packet counts only if bit `pkt_port` of `cfg_port_map` is set. Any number of bits may be set in classes 0 (bandwidth) and 1 (other application-layer). With `cfg_port_en` low, every port passes.
- R3: In class 2 (transaction layer) or class 3 (data link), `cfg_port_en` high together with a `cfg_port_map` that does not have exactly one bit set drives `cfg_invalid` high, and no packet is counted.
- R4: `cfg_port_en` and `cfg_rid_en` both high drives `cfg_invalid` high in any class, and no packet is counted.
- R5: In class 0 with `cfg_rid_en` high, a packet counts only if `pkt_rid` equals `cfg_rid`.
- R6: In class 0 with `cfg_trig_en` high, a packet arms the trigger when its length is strictly greater than 2^`cfg_trig_exp` (mode 0) or strictly less than it (mode 1). No packet is counted before arming, and the arming packet itself is counted if it passes the other filters.
- R7: Once armed, the block stays armed, with `armed` high, until a clear, whatever the lengths of later packets.
- R8: In class 0 with `cfg_thr_en` high, a packet counts only if its length is at least 2^`cfg_thr_exp` (mode 0) or below it (mode 1).
- R9: In classes 1 to 3 the requester, trigger and threshold settings have no effect.
- R10: Each counted packet adds `pkt_len` to `count` one cycle later. The sum saturates at all ones and never wraps.
- R11: With `cnt_en` low, nothing is counted and the trigger does not arm.
- R12: With the trigger disabled or inactive, qualifying packets count from the first enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counting enable |
| cnt_clr | input | 1 | Synchronous clear of count and arming |
| pkt_valid | input | 1 | Descriptor strobe |
| pkt_port | input | PORT_W (4) | Root-port index |
| pkt_rid | input | 16 | Requester identifier |
| pkt_len | input | LEN_W (11) | Packet length in doublewords |
| cfg_class | input | 2 | Event class: 0 bandwidth, 1 application other, 2 transaction layer, 3 data link |
| cfg_port_en | input | 1 | Enable root-port bitmap filter |
| cfg_port_map | input | NPORTS (16) | Root-port bitmap |
| cfg_rid_en | input | 1 | Enable requester match |
| cfg_rid | input | 16 | Requester value to match |
| cfg_trig_en | input | 1 | Enable sticky length trigger |
| cfg_trig_exp | input | 4 | Trigger length exponent |
| cfg_trig_mode | input | 1 | 0: greater than, 1: less than |
| cfg_thr_en | input | 1 | Enable length threshold |
| cfg_thr_exp | input | 4 | Threshold length exponent |
| cfg_thr_mode | input | 1 | 0: at least, 1: below |
| cfg_invalid | output | 1 | Conflicting configuration flag (combinational) |
| armed | output | 1 | Sticky trigger armed state |
| count | output | CNT_W (64) | Saturating doubleword count |

## Verification
`cfg_invalid` follows the configuration in the same cycle. `count` and `armed` respond to a descriptor one clock edge after it is presented. The bench presents every descriptor at a falling edge and lets the rising edge capture it. At the next falling edge it compares `count`, `armed` and `cfg_invalid` with a reference model. The model has already been advanced once for that descriptor, so each result is compared in exactly the cycle it becomes due.

// File: rtl/bwf_pkg.sv
package bwf_pkg;
  typedef enum logic [1:0] {
    CLS_BW   = 2'd0,
    CLS_APP  = 2'd1,
    CLS_TXN  = 2'd2,
    CLS_LINK = 2'd3
  } evclass_e;

  // length against 2^exp: mode 0 strictly above, mode 1 strictly below
  function automatic logic trig_match(input logic [31:0] len, input logic [3:0] e,
                                      input logic mode);
    logic [31:0] lim;
    lim = 32'd1 << e;
    return mode ? (len < lim) : (len > lim);
  endfunction

  // length against 2^exp: mode 0 at or above, mode 1 below
  function automatic logic thr_match(input logic [31:0] len, input logic [3:0] e,
                                     input logic mode);
    logic [31:0] lim;
    lim = 32'd1 << e;
    return mode ? (len < lim) : (len >= lim);
  endfunction
endpackage

// File: rtl/bwf_cfg_check.sv
module bwf_cfg_check #(
  parameter int NPORTS = 16
) (
  input  logic [1:0]        cls_i,
  input  logic              port_en_i,
  input  logic [NPORTS-1:0] port_map_i,
  input  logic              rid_en_i,
  output logic              invalid_o
);
  import bwf_pkg::*;
  logic single_port_cls;
  logic conflict;
  logic bad_single;

  assign single_port_cls = (evclass_e'(cls_i) == CLS_TXN) || (evclass_e'(cls_i) == CLS_LINK);
  assign conflict        = port_en_i && rid_en_i;
  assign bad_single      = single_port_cls && port_en_i && ($countones(port_map_i) != 1);
  assign invalid_o       = conflict || bad_single;
endmodule

// File: rtl/bwf_pkt_filter.sv
module bwf_pkt_filter #(
  parameter int NPORTS = 16,
  parameter int LEN_W  = 11,
  localparam int PORT_W = $clog2(NPORTS)
) (
  input  logic [1:0]        cls_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [15:0]       rid_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              port_en_i,
  input  logic [NPORTS-1:0] port_map_i,
  input  logic              rid_en_i,
  input  logic [15:0]       rid_cfg_i,
  input  logic              trig_en_i,
  input  logic [3:0]        trig_exp_i,
  input  logic              trig_mode_i,
  input  logic              thr_en_i,
  input  logic [3:0]        thr_exp_i,
  input  logic              thr_mode_i,
  output logic              pass_o,
  output logic              trig_active_o,
  output logic              trig_hit_o
);
  import bwf_pkg::*;
  logic is_bw, port_ok, rid_ok, thr_ok;
  logic [31:0] len32;

  assign len32         = 32'(len_i);
  assign is_bw         = (evclass_e'(cls_i) == CLS_BW);
  assign port_ok       = !port_en_i || port_map_i[port_i];
  assign rid_ok        = !(is_bw && rid_en_i) || (rid_i == rid_cfg_i);
  assign thr_ok        = !(is_bw && thr_en_i) || thr_match(len32, thr_exp_i, thr_mode_i);
  assign pass_o        = port_ok && rid_ok && thr_ok;
  assign trig_active_o = is_bw && trig_en_i;
  assign trig_hit_o    = trig_active_o && trig_match(len32, trig_exp_i, trig_mode_i);
endmodule

// File: rtl/bwf_accum.sv
module bwf_accum #(
  parameter int LEN_W = 11,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             invalid_i,
  input  logic             valid_i,
  input  logic             pass_i,
  input  logic             trig_active_i,
  input  logic             trig_hit_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] count_o,
  output logic             armed_o
);
  logic             live;
  logic             gate_open;
  logic             add_now;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] count_q;
  logic             armed_q;

  assign live      = en_i && !invalid_i && valid_i;
  assign gate_open = armed_q || !trig_active_i || trig_hit_i;
  assign add_now   = live && pass_i && gate_open;
  assign sum       = {1'b0, count_q} + (CNT_W+1)'(len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (clr_i) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (live && trig_hit_i) armed_q <= 1'b1;
      if (add_now) count_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

  assign count_o = count_q;
  assign armed_o = armed_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_q == '0) && !armed_q); // R1
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !clr_i) |=> armed_q); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> count_q >= $past(count_q)); // R10
  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_i && !clr_i) |=> $stable(count_q)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(count_q) && ($past(armed_q) == armed_q)); // R11
endmodule

// File: rtl/pcie_bw_filter_counter.sv
module pcie_bw_filter_counter #(
  parameter int NPORTS = 16,
  parameter int LEN_W  = 11,
  parameter int CNT_W  = 64,
  localparam int PORT_W = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              cnt_clr,
  input  logic              pkt_valid,
  input  logic [PORT_W-1:0] pkt_port,
  input  logic [15:0]       pkt_rid,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [1:0]        cfg_class,
  input  logic              cfg_port_en,
  input  logic [NPORTS-1:0] cfg_port_map,
  input  logic              cfg_rid_en,
  input  logic [15:0]       cfg_rid,
  input  logic              cfg_trig_en,
  input  logic [3:0]        cfg_trig_exp,
  input  logic              cfg_trig_mode,
  input  logic              cfg_thr_en,
  input  logic [3:0]        cfg_thr_exp,
  input  logic              cfg_thr_mode,
  output logic              cfg_invalid,
  output logic              armed,
  output logic [CNT_W-1:0]  count
);
  logic pass_w, trig_active_w, trig_hit_w;

  bwf_cfg_check #(.NPORTS(NPORTS)) u_cfg (
    .cls_i(cfg_class), .port_en_i(cfg_port_en), .port_map_i(cfg_port_map),
    .rid_en_i(cfg_rid_en), .invalid_o(cfg_invalid)
  );

  bwf_pkt_filter #(.NPORTS(NPORTS), .LEN_W(LEN_W)) u_filt (
    .cls_i(cfg_class), .port_i(pkt_port), .rid_i(pkt_rid), .len_i(pkt_len),
    .port_en_i(cfg_port_en), .port_map_i(cfg_port_map), .rid_en_i(cfg_rid_en),
    .rid_cfg_i(cfg_rid), .trig_en_i(cfg_trig_en), .trig_exp_i(cfg_trig_exp),
    .trig_mode_i(cfg_trig_mode), .thr_en_i(cfg_thr_en), .thr_exp_i(cfg_thr_exp),
    .thr_mode_i(cfg_thr_mode), .pass_o(pass_w), .trig_active_o(trig_active_w),
    .trig_hit_o(trig_hit_w)
  );

  bwf_accum #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .en_i(cnt_en), .invalid_i(cfg_invalid),
    .valid_i(pkt_valid), .pass_i(pass_w), .trig_active_i(trig_active_w),
    .trig_hit_i(trig_hit_w), .len_i(pkt_len), .count_o(count), .armed_o(armed)
  );

  AST_TRIG_ONLY_BW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_class != 2'd0 && !cnt_clr && !$past(cnt_clr)) |=> ($past(armed) == armed)); // R9
endmodule

// File: tb/pcie_bw_filter_counter_tb.sv
module pcie_bw_filter_counter_tb;
  localparam int NP = 16;
  localparam int LW = 11;
  localparam int CW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic cnt_en = 0, cnt_clr = 0, pkt_valid = 0;
  logic [3:0] pkt_port = 0;
  logic [15:0] pkt_rid = 0;
  logic [LW-1:0] pkt_len = 0;
  logic [1:0] cfg_class = 0;
  logic cfg_port_en = 0, cfg_rid_en = 0, cfg_trig_en = 0, cfg_trig_mode = 0;
  logic cfg_thr_en = 0, cfg_thr_mode = 0;
  logic [NP-1:0] cfg_port_map = 0;
  logic [15:0] cfg_rid = 0;
  logic [3:0] cfg_trig_exp = 0, cfg_thr_exp = 0;
  logic cfg_invalid, armed;
  logic [CW-1:0] count;

  int checks = 0, failures = 0;
  logic [CW-1:0] m_cnt = 0;
  logic m_arm = 0;

  always #2.5 clk = ~clk;

  pcie_bw_filter_counter #(.NPORTS(NP), .LEN_W(LW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr), .pkt_valid(pkt_valid),
    .pkt_port(pkt_port), .pkt_rid(pkt_rid), .pkt_len(pkt_len), .cfg_class(cfg_class),
    .cfg_port_en(cfg_port_en), .cfg_port_map(cfg_port_map), .cfg_rid_en(cfg_rid_en),
    .cfg_rid(cfg_rid), .cfg_trig_en(cfg_trig_en), .cfg_trig_exp(cfg_trig_exp),
    .cfg_trig_mode(cfg_trig_mode), .cfg_thr_en(cfg_thr_en), .cfg_thr_exp(cfg_thr_exp),
    .cfg_thr_mode(cfg_thr_mode), .cfg_invalid(cfg_invalid), .armed(armed), .count(count)
  );

  function automatic bit exp_invalid();
    int bits = 0;
    for (int i = 0; i < NP; i++) bits += int'(cfg_port_map[i]);
    return (cfg_port_en && cfg_rid_en) || (cfg_class >= 2 && cfg_port_en && bits != 1);
  endfunction

  // length vs power of two computed by repeated doubling
  function automatic int pow2(input int e);
    int p = 1;
    for (int i = 0; i < e; i++) p = p * 2;
    return p;
  endfunction

  function automatic void model_step();
    bit bw, ok, hit, gate;
    int lim_t, lim_h, total;
    if (cnt_clr) begin m_cnt = 0; m_arm = 0; return; end
    if (!cnt_en || exp_invalid() || !pkt_valid) return;
    bw = (cfg_class == 0);
    lim_t = pow2(int'(cfg_trig_exp));
    lim_h = pow2(int'(cfg_thr_exp));
    hit = bw && cfg_trig_en &&
          (cfg_trig_mode ? int'(pkt_len) < lim_t : int'(pkt_len) > lim_t);
    gate = m_arm || !(bw && cfg_trig_en) || hit;
    if (hit) m_arm = 1;
    ok = (!cfg_port_en || cfg_port_map[pkt_port]) &&
         (!(bw && cfg_rid_en) || pkt_rid == cfg_rid) &&
         (!(bw && cfg_thr_en) ||
          (cfg_thr_mode ? int'(pkt_len) < lim_h : int'(pkt_len) >= lim_h));
    if (ok && gate) begin
      total = int'(m_cnt) + int'(pkt_len);
      m_cnt = (total > 65535) ? 16'hFFFF : CW'(total);
    end
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // at a falling edge: drive, advance model, wait one cycle, compare
  task automatic step(input string tag, input bit v, input int port, input int rid,
                      input int len, input bit clr);
    pkt_valid = v; pkt_port = 4'(port); pkt_rid = 16'(rid); pkt_len = LW'(len);
    cnt_clr = clr;
    model_step();
    @(negedge clk);
    check({tag, " count"}, count, m_cnt);
    check({tag, " armed"}, CW'(armed), CW'(m_arm));
    check({tag, " invalid"}, CW'(cfg_invalid), CW'(exp_invalid()));
    pkt_valid = 0; cnt_clr = 0;
  endtask

  task automatic cfg_off();
    cfg_class = 1; cfg_port_en = 0; cfg_rid_en = 0; cfg_trig_en = 0; cfg_thr_en = 0;
    cfg_port_map = 0; cfg_trig_mode = 0; cfg_thr_mode = 0;
  endtask

  initial begin
    #400000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset count", count, 0);
    check("R1 reset armed", CW'(armed), 0);

    cfg_off(); cnt_en = 1;
    step("R12 immediate count", 1, 3, 0, 5, 0);
    step("R10 add length", 1, 9, 0, 100, 0);
    step("R1 clear wins over packet", 1, 0, 0, 50, 1);

    cfg_port_en = 1; cfg_port_map = 16'h0088;
    step("R2 port 3 selected", 1, 3, 0, 4, 0);
    step("R2 port 5 rejected", 1, 5, 0, 4, 0);
    step("R2 port 7 selected", 1, 7, 0, 2, 0);

    cfg_class = 2;
    step("R3 two ports in txn class", 1, 3, 0, 9, 0);
    cfg_class = 3; cfg_port_map = 16'h0000;
    step("R3 zero ports in link class", 1, 3, 0, 9, 0);
    cfg_port_map = 16'h0100;
    step("R3 single port valid", 1, 8, 0, 6, 0);

    cfg_class = 0; cfg_rid_en = 1;
    step("R4 port and rid together", 1, 8, 16'h3900, 7, 0);

    cfg_off(); cfg_class = 0; cfg_rid_en = 1; cfg_rid = 16'h3900;
    step("R1 clear", 0, 0, 0, 0, 1);
    step("R5 rid match", 1, 1, 16'h3900, 12, 0);
    step("R5 rid mismatch", 1, 1, 16'h3901, 12, 0);

    cfg_rid_en = 0; cfg_trig_en = 1; cfg_trig_exp = 4; cfg_trig_mode = 0;
    step("R1 clear", 0, 0, 0, 0, 1);
    step("R6 equal does not arm", 1, 0, 0, 16, 0);
    step("R6 short does not arm", 1, 0, 0, 8, 0);
    step("R6 arming packet counted", 1, 0, 0, 17, 0);
    step("R7 stays armed", 1, 0, 0, 3, 0);
    cfg_trig_mode = 1;
    step("R1 clear", 0, 0, 0, 0, 1);
    step("R6 below mode long", 1, 0, 0, 20, 0);
    step("R6 below mode arms", 1, 0, 0, 15, 0);
    step("R7 long after arming", 1, 0, 0, 40, 0);

    cfg_trig_en = 0; cfg_thr_en = 1; cfg_thr_exp = 3; cfg_thr_mode = 0;
    step("R1 clear", 0, 0, 0, 0, 1);
    step("R8 at-least rejects 7", 1, 0, 0, 7, 0);
    step("R8 at-least takes 8", 1, 0, 0, 8, 0);
    cfg_thr_mode = 1;
    step("R8 below rejects 8", 1, 0, 0, 8, 0);
    step("R8 below takes 7", 1, 0, 0, 7, 0);

    cfg_class = 1; cfg_rid_en = 1; cfg_rid = 16'h1234; cfg_trig_en = 1;
    cfg_trig_exp = 10; cfg_trig_mode = 0;
    step("R9 filters ignored", 1, 2, 16'h4321, 9, 0);

    cnt_en = 0; cfg_class = 0; cfg_rid_en = 0; cfg_thr_en = 0; cfg_trig_exp = 2;
    step("R11 disabled no count", 1, 2, 0, 30, 0);
    step("R11 disabled no arm", 1, 2, 0, 31, 0);

    cfg_off(); cnt_en = 1;
    for (int i = 0; i < 40; i++) step("R10 saturation", 1, 0, 0, 2000, 0);
    check("R10 saturated value", count, 16'hFFFF);

    for (int blk = 0; blk < 60; blk++) begin
      cfg_class     = 2'($urandom_range(0, 3));
      cfg_port_en   = 1'($urandom_range(0, 1));
      cfg_port_map  = ($urandom_range(0, 1) == 1) ? NP'(1) << $urandom_range(0, NP-1)
                                                   : NP'($urandom);
      cfg_rid_en    = ($urandom_range(0, 3) == 0);
      cfg_rid       = 16'($urandom_range(0, 3));
      cfg_trig_en   = 1'($urandom_range(0, 1));
      cfg_trig_exp  = 4'($urandom_range(0, 11));
      cfg_trig_mode = 1'($urandom_range(0, 1));
      cfg_thr_en    = 1'($urandom_range(0, 1));
      cfg_thr_exp   = 4'($urandom_range(0, 11));
      cfg_thr_mode  = 1'($urandom_range(0, 1));
      cnt_en        = ($urandom_range(0, 7) != 0);
      for (int k = 0; k < 40; k++)
        step("R10 random mix", ($urandom_range(0, 3) != 0), $urandom_range(0, NP-1),
             $urandom_range(0, 3), $urandom_range(0, 2047), (k == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule